// File: doc/BRIEF.md
# GFP/LAPS Transmit Frame Encapsulator

This block turns Ethernet frames arriving as a byte stream (valid/ready with start and end markers) into encapsulated frames for a byte-oriented SONET/SDH mapper. Two encapsulations are available. In LAPS-style mode each frame is one programmable header byte, then the payload, then a 32-bit FCS. In GFP-style mode the same content is preceded by a four-byte core header. That core header holds a payload length indicator and its CRC-16 check, and it is DC-balanced with a fixed XOR pattern.

Every byte after the core header goes through a self-synchronous x^43+1 scrambler. Its history runs on from one frame to the next. A small control bank selects the mode and the header byte. It also has switches that bypass the scrambler, drop the FCS, force a wrong FCS, and suppress the header byte, with one suppress switch per mode. Software writes the bank at any time, and the block copies it into the working configuration only when a new frame opens.

The FSM states are IDLE (waiting for a start marker), OPEN (one cycle to adopt the new configuration), CORE (four core-header bytes), HDR (header byte), PAY (payload pass-through) and FCS (four check bytes). The transitions are:
- IDLE→OPEN when a start byte is presented.
- OPEN→CORE in GFP mode. In LAPS mode OPEN goes to HDR, or to PAY when the header is suppressed.
- CORE→HDR or CORE→PAY after the fourth byte.
- HDR→PAY.
- PAY→FCS on the end byte, or PAY→IDLE on the end byte when the FCS is inhibited.
- FCS→IDLE after the fourth byte.

Top module: `gfp_laps_tx_encap`

## Requirements
- R1: After reset no output byte is valid, the block is in LAPS mode with every switch off, and the header byte is 0x04. The first frame after reset therefore starts with byte 0x04 on the line.
- R2: A LAPS frame is sent as header byte, payload bytes, then four FCS bytes. out_sof marks only the first byte of the frame and out_eof marks only the last.
- R3: The FCS is the reflected CRC-32 (polynomial 0x04C11DB7, preset 0xFFFFFFFF, final complement). It covers the header byte when that byte is sent, plus the payload, and is sent least-significant byte first.
- R4: Each byte after the core header is scrambled MSB first, where each output bit is the input bit XOR the output bit 43 bit-times earlier. The history starts at all zeros after reset and carries across frames.
- R5: With ctrl_scr_off set, bytes pass unscrambled and the scrambler history is left untouched, so a later scrambled frame continues from the older history.
- R6: With ctrl_fcs_off set, no FCS bytes are sent and out_eof marks the last payload byte.
- R7: With ctrl_fcs_bad set, all 32 FCS bits are inverted relative to the correct value. ctrl_fcs_bad has no effect while ctrl_fcs_off is set.
- R8: ctrl_laps_hdr_off suppresses the header byte only in LAPS mode, and ctrl_gfp_hdr_off only in GFP mode. A suppressed header is also left out of the FCS.
- R9: In GFP mode the frame opens with four core-header bytes, sent MSB first. These are {PLI[15:0], HEC[15:0]} XOR 0xB6AB31E0. PLI counts the bytes after the core header. HEC is the CRC-16 x^16+x^12+x^5+1 (preset 0, MSB first) over the two PLI bytes. These bytes are never scrambled, even while scrambling is on.
- R10: A control write takes effect only at the next frame start. A frame already under way keeps the settings it opened with.
- R11: in_ready is low from the cycle a start byte is presented until the payload state. That stall is 3 cycles for LAPS with header, 2 for LAPS without, 7 for GFP with header and 6 for GFP without. Non-start bytes offered while idle are accepted and dropped, with no output.
- R12: Each accepted payload byte appears on out_data one cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control bank |
| ctrl_gfp | input | 1 | 1 selects GFP-style, 0 LAPS-style |
| ctrl_scr_off | input | 1 | Bypass payload scrambler |
| ctrl_fcs_off | input | 1 | Omit the FCS |
| ctrl_fcs_bad | input | 1 | Send an inverted FCS |
| ctrl_laps_hdr_off | input | 1 | Suppress header byte in LAPS mode |
| ctrl_gfp_hdr_off | input | 1 | Suppress header byte in GFP mode |
| ctrl_hdr_byte | input | 8 | Header byte (address or {DP,SP}) |
| in_data | input | 8 | Ethernet frame byte |
| in_valid | input | 1 | in_data is valid |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_len | input | 16 | Payload length in bytes, sampled with the start byte |
| in_ready | output | 1 | Byte accepted on this edge when valid |
| out_data | output | 8 | Encapsulated line byte |
| out_valid | output | 1 | out_data is valid |
| out_sof | output | 1 | First byte of an encapsulated frame |
| out_eof | output | 1 | Last byte of an encapsulated frame |

## Verification
The bench builds the block with its default parameters: a 43-bit scrambler lag, a 0x04 header reset value and the 0xB6AB31E0 balancing mask. These are the values its independent bit-serial scrambler, CRC-32 and CRC-16 models assume. With these values a zero-history first frame puts the reset header byte on the line unchanged. Short frames then walk the scrambler history across frames with scrambling on and off, and cover every stall length through the OPEN, CORE and HDR states. A control write landing mid-frame shows that a frame keeps the settings it opened with.

// File: rtl/encap_pkg.sv
package encap_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int PLI_W      = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_CORE,
        ST_HDR,
        ST_PAY,
        ST_FCS
    } enc_state_e;

    typedef struct packed {
        logic              gfp;
        logic              scr_off;
        logic              fcs_off;
        logic              fcs_bad;
        logic              laps_hdr_off;
        logic              gfp_hdr_off;
        logic [BYTE_W-1:0] hdr;
    } enc_cfg_t;

    // reflected CRC-32 step over one byte, LSB first
    function automatic logic [31:0] crc32_step(logic [31:0] c, logic [BYTE_W-1:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB8_8320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // CRC-16 x^16+x^12+x^5+1 step over one byte, MSB first
    function automatic logic [15:0] crc16_step(logic [15:0] c, logic [BYTE_W-1:0] d);
        logic [15:0] r;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/encap_ctrl_bank.sv
module encap_ctrl_bank
    import encap_pkg::*;
#(
    parameter logic [BYTE_W-1:0] HDR_RST = 8'h04
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  enc_cfg_t wr_cfg,
    input  logic     take,
    output enc_cfg_t act_cfg
);

    localparam enc_cfg_t CFG_RST = '{
        gfp:          1'b0,
        scr_off:      1'b0,
        fcs_off:      1'b0,
        fcs_bad:      1'b0,
        laps_hdr_off: 1'b0,
        gfp_hdr_off:  1'b0,
        hdr:          HDR_RST
    };

    enc_cfg_t pend_q;

    // pending copy follows writes; working copy moves only at frame open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= CFG_RST;
            act_cfg <= CFG_RST;
        end else begin
            if (wr_en) pend_q  <= wr_cfg;
            if (take)  act_cfg <= pend_q;
        end
    end

endmodule

// File: rtl/encap_scrambler.sv
module encap_scrambler
    import encap_pkg::*;
#(
    parameter int LAG = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    localparam int KEEP = LAG - BYTE_W;

    logic [LAG-1:0] hist_q;

    generate
        if (LAG <= BYTE_W) begin : g_bad_lag
            initial $error("scrambler lag must exceed the byte width");
        end
    endgenerate

    // hist_q[0] is the newest line bit; bit 7 of a byte leaves first
    assign dout = din ^ hist_q[LAG-1 -: BYTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist_q <= '0;
        else if (adv) hist_q <= {hist_q[KEEP-1:0], dout};
    end

endmodule

// File: rtl/encap_fcs_acc.sv
module encap_fcs_acc
    import encap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [31:0]       crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= 32'hFFFF_FFFF;
        else if (init) crc <= 32'hFFFF_FFFF;
        else if (upd)  crc <= crc32_step(crc, din);
    end

endmodule

// File: rtl/encap_core_header.sv
module encap_core_header
    import encap_pkg::*;
#(
    parameter logic [31:0] DC_MASK = 32'hB6AB_31E0
) (
    input  logic [PLI_W-1:0] len,
    input  logic             hdr_on,
    input  logic             fcs_on,
    output logic [31:0]      word
);

    logic [PLI_W-1:0] pli;
    logic [15:0]      hec;

    always_comb begin
        pli  = len + PLI_W'(hdr_on) + (fcs_on ? PLI_W'(WORD_BYTES) : '0);
        hec  = crc16_step(crc16_step(16'h0000, pli[15:8]), pli[7:0]);
        word = {pli, hec} ^ DC_MASK;
    end

endmodule

// File: rtl/gfp_laps_tx_encap.sv
module gfp_laps_tx_encap
    import encap_pkg::*;
#(
    parameter int                SCR_LAG = 43,
    parameter logic [BYTE_W-1:0] HDR_RST = 8'h04,
    parameter logic [31:0]       DC_MASK = 32'hB6AB_31E0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic        ctrl_gfp,
    input  logic        ctrl_scr_off,
    input  logic        ctrl_fcs_off,
    input  logic        ctrl_fcs_bad,
    input  logic        ctrl_laps_hdr_off,
    input  logic        ctrl_gfp_hdr_off,
    input  logic [7:0]  ctrl_hdr_byte,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [15:0] in_len,
    output logic        in_ready,
    output logic [7:0]  out_data,
    output logic        out_valid,
    output logic        out_sof,
    output logic        out_eof
);

    localparam int               IDX_W    = $clog2(WORD_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_BYTES - 1);

    enc_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              first_q;
    logic [PLI_W-1:0]  len_q;
    logic              take, crc_init;
    enc_cfg_t          wr_cfg, act_cfg;
    logic              hdr_on, fcs_on;
    logic [31:0]       core_word, crc_q, fcs_word;
    logic              emit, scr_sel, crc_upd, last_b, scr_adv;
    logic [BYTE_W-1:0] raw_b, scr_b, tx_b;

    assign wr_cfg = '{
        gfp:          ctrl_gfp,
        scr_off:      ctrl_scr_off,
        fcs_off:      ctrl_fcs_off,
        fcs_bad:      ctrl_fcs_bad,
        laps_hdr_off: ctrl_laps_hdr_off,
        gfp_hdr_off:  ctrl_gfp_hdr_off,
        hdr:          ctrl_hdr_byte
    };

    encap_ctrl_bank #(.HDR_RST(HDR_RST)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_we),
        .wr_cfg  (wr_cfg),
        .take    (take),
        .act_cfg (act_cfg)
    );

    assign hdr_on = act_cfg.gfp ? !act_cfg.gfp_hdr_off : !act_cfg.laps_hdr_off;
    assign fcs_on = !act_cfg.fcs_off;

    encap_core_header #(.DC_MASK(DC_MASK)) u_core (
        .len    (len_q),
        .hdr_on (hdr_on),
        .fcs_on (fcs_on),
        .word   (core_word)
    );

    encap_fcs_acc u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .din   (raw_b),
        .crc   (crc_q)
    );

    assign fcs_word = act_cfg.fcs_bad ? crc_q : ~crc_q;
    assign scr_adv  = emit && scr_sel && !act_cfg.scr_off;

    encap_scrambler #(.LAG(SCR_LAG)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (scr_adv),
        .din   (raw_b),
        .dout  (scr_b)
    );

    assign tx_b     = (scr_sel && !act_cfg.scr_off) ? scr_b : raw_b;
    assign in_ready = (state_q == ST_PAY) || ((state_q == ST_IDLE) && !in_sop);

    // next-state logic
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        take     = 1'b0;
        crc_init = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sop) begin
                    take     = 1'b1;
                    crc_init = 1'b1;
                    idx_d    = '0;
                    state_d  = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (act_cfg.gfp) state_d = ST_CORE;
                else             state_d = hdr_on ? ST_HDR : ST_PAY;
            end
            ST_CORE: begin
                idx_d = idx_q + IDX_W'(1);
                if (idx_q == IDX_LAST) state_d = hdr_on ? ST_HDR : ST_PAY;
            end
            ST_HDR: state_d = ST_PAY;
            ST_PAY: begin
                if (in_valid && in_eop) state_d = fcs_on ? ST_FCS : ST_IDLE;
            end
            ST_FCS: begin
                idx_d = idx_q + IDX_W'(1);
                if (idx_q == IDX_LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        emit    = 1'b0;
        scr_sel = 1'b0;
        crc_upd = 1'b0;
        last_b  = 1'b0;
        raw_b   = '0;
        unique case (state_q)
            ST_IDLE, ST_OPEN: ;
            ST_CORE: begin
                emit  = 1'b1;
                raw_b = core_word[BYTE_W*int'(IDX_LAST - idx_q) +: BYTE_W];
            end
            ST_HDR: begin
                emit    = 1'b1;
                scr_sel = 1'b1;
                crc_upd = 1'b1;
                raw_b   = act_cfg.hdr;
            end
            ST_PAY: begin
                if (in_valid) begin
                    emit    = 1'b1;
                    scr_sel = 1'b1;
                    crc_upd = 1'b1;
                    raw_b   = in_data;
                    last_b  = in_eop && !fcs_on;
                end
            end
            ST_FCS: begin
                emit    = 1'b1;
                scr_sel = 1'b1;
                raw_b   = fcs_word[BYTE_W*int'(idx_q) +: BYTE_W];
                last_b  = (idx_q == IDX_LAST);
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            first_q <= 1'b0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (take) begin
                first_q <= 1'b1;
                len_q   <= in_len;
            end else if (emit) begin
                first_q <= 1'b0;
            end
        end
    end

    // line-side output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= emit;
            out_data  <= emit ? tx_b : '0;
            out_sof   <= emit && first_q;
            out_eof   <= emit && last_b;
        end
    end

endmodule

// File: rtl/gfp_laps_tx_encap_chk.sv
module gfp_laps_tx_encap_chk
    import encap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input enc_state_e state_q,
    input logic       take,
    input enc_cfg_t   act_cfg,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof
);

    // R2
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R2
    eof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R2
    eof_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (state_q == ST_IDLE));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(act_cfg));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_OPEN) |=> !out_valid);

    // R12
    pay_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAY && in_valid && in_ready) |=> out_valid);

endmodule

bind gfp_laps_tx_encap gfp_laps_tx_encap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .take      (take),
    .act_cfg   (act_cfg),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
);

// File: tb/gfp_laps_tx_encap_tb_top.sv
module gfp_laps_tx_encap_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0, ctrl_gfp = 1'b0, ctrl_scr_off = 1'b0, ctrl_fcs_off = 1'b0;
    logic        ctrl_fcs_bad = 1'b0, ctrl_laps_hdr_off = 1'b0, ctrl_gfp_hdr_off = 1'b0;
    logic [7:0]  ctrl_hdr_byte = 8'h00;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [15:0] in_len = 16'h0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid, out_sof, out_eof;

    always #4 clk = ~clk;

    gfp_laps_tx_encap dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_gfp(ctrl_gfp), .ctrl_scr_off(ctrl_scr_off),
        .ctrl_fcs_off(ctrl_fcs_off), .ctrl_fcs_bad(ctrl_fcs_bad),
        .ctrl_laps_hdr_off(ctrl_laps_hdr_off), .ctrl_gfp_hdr_off(ctrl_gfp_hdr_off),
        .ctrl_hdr_byte(ctrl_hdr_byte),
        .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_len(in_len), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    always @(posedge clk) cyc++;

    // bench model of the control bank
    bit         m_gfp = 0, m_scr_off = 0, m_fcs_off = 0, m_fcs_bad = 0, m_lho = 0, m_gho = 0;
    logic [7:0] m_hdr = 8'h04;
    logic [42:0] m_hist = '0;

    logic [7:0] pay [0:63];
    int         pay_n = 0;
    logic [7:0] exp_d [0:127];
    int         exp_n = 0;
    logic [7:0] cap_d [0:127];
    bit         cap_s [0:127];
    bit         cap_e [0:127];
    int         cap_n = 0, cap_cyc_e = 0, stall = 0, last_xfer_cyc = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 128) begin
            cap_d[cap_n] = out_data;
            cap_s[cap_n] = out_sof;
            cap_e[cap_n] = out_eof;
            if (out_eof) cap_cyc_e = cyc;
            cap_n++;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_crc32(logic [31:0] c, logic [7:0] d);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic logic [15:0] m_crc16(logic [15:0] c, logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ d[i];
            r = r << 1;
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    // bit-serial line model: each bit XOR the line bit 43 positions back
    function automatic logic [7:0] m_scr(logic [7:0] b);
        logic [7:0] o;
        for (int k = 7; k >= 0; k--) begin
            o[k]   = b[k] ^ m_hist[42];
            m_hist = {m_hist[41:0], o[k]};
        end
        return o;
    endfunction

    task automatic write_ctrl(bit g, bit so, bit fo, bit fb, bit lho, bit gho, logic [7:0] h);
        ctrl_gfp = g; ctrl_scr_off = so; ctrl_fcs_off = fo; ctrl_fcs_bad = fb;
        ctrl_laps_hdr_off = lho; ctrl_gfp_hdr_off = gho; ctrl_hdr_byte = h; ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
        m_gfp = g; m_scr_off = so; m_fcs_off = fo; m_fcs_bad = fb; m_lho = lho; m_gho = gho; m_hdr = h;
    endtask

    task automatic fill(int n, int seed);
        pay_n = n;
        for (int i = 0; i < n; i++) pay[i] = 8'(seed * 7 + i * 13 + 1);
    endtask

    task automatic build_expect();
        logic [7:0]  rb [0:127];
        bit          sc [0:127];
        int          n = 0;
        bit          hon;
        logic [31:0] c, f, w;
        logic [15:0] pli, hec;
        hon = m_gfp ? !m_gho : !m_lho;
        if (m_gfp) begin
            pli = 16'(pay_n + (hon ? 1 : 0) + (m_fcs_off ? 0 : 4));
            hec = m_crc16(m_crc16(16'h0, pli[15:8]), pli[7:0]);
            w   = {pli, hec} ^ 32'hB6AB31E0;
            for (int k = 3; k >= 0; k--) begin rb[n] = w[8*k +: 8]; sc[n] = 0; n++; end
        end
        c = 32'hFFFFFFFF;
        if (hon) begin rb[n] = m_hdr; sc[n] = 1; n++; c = m_crc32(c, m_hdr); end
        for (int i = 0; i < pay_n; i++) begin
            rb[n] = pay[i]; sc[n] = 1; n++; c = m_crc32(c, pay[i]);
        end
        if (!m_fcs_off) begin
            f = ~c;
            if (m_fcs_bad) f = ~f;
            for (int k = 0; k < 4; k++) begin rb[n] = f[8*k +: 8]; sc[n] = 1; n++; end
        end
        for (int i = 0; i < n; i++) exp_d[i] = (sc[i] && !m_scr_off) ? m_scr(rb[i]) : rb[i];
        exp_n = n;
    endtask

    task automatic send_frame();
        stall = 0;
        for (int i = 0; i < pay_n; i++) begin
            in_data = pay[i]; in_valid = 1'b1; in_sop = (i == 0);
            in_eop = (i == pay_n - 1); in_len = 16'(pay_n);
            #1;
            while (!in_ready) begin
                if (i == 0) stall++;
                @(negedge clk);
                #1;
            end
            last_xfer_cyc = cyc;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic compare(string req);
        int bad = -1, bad_a = 0, bad_e = 0, mn;
        bit mk = 1;
        mn = (cap_n < exp_n) ? cap_n : exp_n;
        chk(cap_n == exp_n, req, "frame length", cap_n, exp_n);
        for (int i = 0; i < mn; i++)
            if (bad < 0 && cap_d[i] !== exp_d[i]) begin bad = i; bad_a = cap_d[i]; bad_e = exp_d[i]; end
        chk(bad < 0, req, $sformatf("byte %0d", bad), bad_a, bad_e);
        for (int i = 0; i < mn; i++)
            if (cap_s[i] != (i == 0) || cap_e[i] != (i == exp_n - 1)) mk = 0;
        chk(mk, req, "sof/eof markers", mk, 1);
    endtask

    task automatic run_frame(string req, int n, int seed);
        fill(n, seed);
        build_expect();
        cap_n = 0;
        send_frame();
        repeat (8) @(negedge clk);
        compare(req);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready idle", in_ready, 1);
    endtask

    task automatic t_laps_basic();
        run_frame("R1 R2 R3 R4 laps default", 6, 1);
        chk(cap_d[0] == 8'h04, "R1", "first byte header default", cap_d[0], 8'h04);
        chk(stall == 3, "R11", "laps hdr stall", stall, 3);
        run_frame("R4 scrambler carries over", 9, 2);
    endtask

    task automatic t_scr_off();
        write_ctrl(0, 1, 0, 0, 0, 0, 8'h5A);
        run_frame("R5 bypass", 5, 3);
        write_ctrl(0, 0, 0, 0, 0, 0, 8'h5A);
        run_frame("R5 history kept", 5, 4);
    endtask

    task automatic t_fcs();
        write_ctrl(0, 0, 1, 0, 0, 0, 8'h21);
        run_frame("R6 fcs omitted", 7, 5);
        chk(cap_cyc_e == last_xfer_cyc + 1, "R12", "payload latency", cap_cyc_e, last_xfer_cyc + 1);
        write_ctrl(0, 0, 0, 1, 0, 0, 8'h21);
        run_frame("R7 fcs inverted", 4, 6);
        write_ctrl(0, 0, 1, 1, 0, 0, 8'h21);
        run_frame("R7 corrupt ignored when omitted", 4, 7);
        chk(cap_n == 5, "R7", "length with off+bad", cap_n, 5);
    endtask

    task automatic t_hdr();
        write_ctrl(0, 0, 0, 0, 1, 0, 8'h33);
        run_frame("R8 laps header off", 5, 8);
        chk(stall == 2, "R11", "laps no-hdr stall", stall, 2);
        write_ctrl(0, 0, 0, 0, 0, 1, 8'h33);
        run_frame("R8 gfp switch no effect in laps", 5, 9);
    endtask

    task automatic t_gfp();
        write_ctrl(1, 0, 0, 0, 0, 0, 8'hC1);
        run_frame("R9 gfp frame", 8, 10);
        chk(stall == 7, "R11", "gfp hdr stall", stall, 7);
        write_ctrl(1, 1, 0, 0, 0, 0, 8'hC1);
        run_frame("R9 balancing kept with scr off", 6, 11);
        write_ctrl(1, 0, 0, 0, 1, 0, 8'hC1);
        run_frame("R8 laps switch no effect in gfp", 3, 12);
        write_ctrl(1, 0, 0, 0, 0, 1, 8'hC1);
        run_frame("R8 gfp header off", 6, 13);
        chk(stall == 6, "R11", "gfp no-hdr stall", stall, 6);
        write_ctrl(1, 0, 1, 0, 0, 0, 8'h9E);
        run_frame("R9 pli without fcs", 10, 14);
    endtask

    task automatic t_mid_write();
        write_ctrl(0, 0, 0, 0, 0, 0, 8'h77);
        fill(12, 15);
        build_expect();
        cap_n = 0;
        fork
            send_frame();
            begin repeat (5) @(negedge clk); write_ctrl(1, 1, 1, 0, 0, 0, 8'hE4); end
        join
        repeat (8) @(negedge clk);
        compare("R10 write mid-frame");
        run_frame("R10 new settings next frame", 4, 16);
    endtask

    task automatic t_stray();
        int hold;
        cap_n = 0;
        hold = 1;
        for (int i = 0; i < 3; i++) begin
            in_data = 8'hF0 + 8'(i); in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b0;
            #1;
            if (!in_ready) hold = 0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(hold == 1, "R11", "stray bytes accepted", hold, 1);
        chk(cap_n == 0, "R11", "stray bytes no output", cap_n, 0);
        run_frame("R11 frame after stray", 5, 17);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_laps_basic();
        t_scr_off();
        t_fcs();
        t_hdr();
        t_gfp();
        t_mid_write();
        t_stray();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule